// File: doc/BRIEF.md
# SD Host Interrupt Status and Mask Unit

This block gathers the interrupt events of an SD card host controller into one sticky status word and turns them into a single level interrupt. Each event source delivers a one-cycle pulse. The pulse sets its own status bit, and that bit stays set until the host acknowledges it. The host acknowledges by writing the status word, where a 0 in a bit position clears that bit. A mask word holds one bit per source, and a set mask bit keeps that source from raising the interrupt. Two level inputs are shown live in the status word: the write-protect switch and the card signal state. They are not latched and they never interrupt.

The block has a small synchronous register port with four addresses. Address 0 is the status word. Address 1 is the mask word, written directly. Address 2 enables sources by clearing the mask bits written as 1. Address 3 disables sources by setting the mask bits written as 1. Besides the interrupt level, the block reports a cause code for the highest-priority group that is pending and unmasked. The driver uses this code to choose its handler without scanning the status word.

Top module: `sdirq_collector`

## Requirements
- R1: After reset the status word reads 0 (with both level inputs low), the mask word reads all ones, `irq_o` is 0 and `cause_o` is 0.
- R2: A pulse on an implemented event input sets the matching status bit at the next clock edge. The bit stays set until it is acknowledged. The implemented event bits are: card insert (bit 0), card remove (bit 1), command done (bit 4), command timeout (bit 5), receive ready (bit 6), transmit request (bit 7) and data end (bit 8).
- R3: A write to address 0 clears every status bit written as 0 and leaves every status bit written as 1 unchanged.
- R4: When an event pulse and an acknowledge write that clears the same bit arrive in the same cycle, the bit stays set.
- R5: A write to address 1 loads the mask word. A write to address 2 clears the mask bits written as 1. A write to address 3 sets the mask bits written as 1. Reading any of addresses 1 to 3 returns the mask word.
- R6: A status bit whose mask bit is 1 still reads as set but does not raise `irq_o`.
- R7: `irq_o` is the OR of (status AND implemented-bits AND NOT mask), taken one clock after the state that produced it.
- R8: `cause_o` is registered together with `irq_o`. It reports the highest pending group in this order: 1 for card insert or remove, 2 for command done or timeout, 3 for receive ready or transmit request, 4 for data end, and 0 when nothing is pending.
- R9: The write-protect level (`lvl_i[0]`) reads live at status bit 2 and the signal-state level (`lvl_i[1]`) reads live at status bit 3. Neither is latched, neither is changed by status writes, and neither raises `irq_o`.
- R10: Pulses on unimplemented event inputs have no effect. The unimplemented status bits always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | DW | One-cycle event pulses, one per status bit |
| lvl_i | input | 2 | Live levels: [0] write protect, [1] signal state |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 status, 1 mask, 2 enable sources, 3 disable sources |
| wdata | input | DW | Write data |
| rdata | output | DW | Read data for `addr`, combinational |
| irq_o | output | 1 | Level interrupt |
| cause_o | output | 3 | Highest pending group code |

## Verification
A status bit that is wrongly held or wrongly dropped shows up on `rdata` in the cycle right after the event or write. One clock later it also shows up as a wrong `irq_o` or `cause_o`. A corrupted mask bit does not change the status read. It shows only through the interrupt, one clock after the mask write. The bench therefore reads the mask word back directly, and it reads `irq_o` both before and after the one-cycle lag. Mixed groups are acknowledged in stages, so an error in the priority order changes the cause code at a known step.

// File: rtl/sdirq_pkg.sv
package sdirq_pkg;
   // status bit positions; driver decodes these
   localparam int unsigned B_CIN   = 0;
   localparam int unsigned B_COUT  = 1;
   localparam int unsigned B_WP    = 2;
   localparam int unsigned B_SIG   = 3;
   localparam int unsigned B_CDONE = 4;
   localparam int unsigned B_CTMO  = 5;
   localparam int unsigned B_RXR   = 6;
   localparam int unsigned B_TXQ   = 7;
   localparam int unsigned B_DEND  = 8;
   localparam int unsigned N_USED  = 9;

   typedef enum logic [2:0] {
      CZ_NONE = 3'd0,
      CZ_CARD = 3'd1,
      CZ_CMD  = 3'd2,
      CZ_XFER = 3'd3,
      CZ_DEND = 3'd4
   } cause_e;

   typedef enum logic [1:0] {
      A_STAT   = 2'd0,
      A_MASK   = 2'd1,
      A_UNMASK = 2'd2,
      A_DOMASK = 2'd3
   } reg_addr_e;
endpackage

// File: rtl/sdirq_status.sv
module sdirq_status #(
   parameter int unsigned DW = 32,
   parameter logic [DW-1:0] IMPL = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] evt,
   input  logic          ack_we,
   input  logic [DW-1:0] ack_data,
   output logic [DW-1:0] stat_q
);
   logic [DW-1:0] kept;

   // zeros in ack_data clear; new events override the clear
   always_comb kept = ack_we ? (stat_q & ack_data) : stat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= (kept | evt) & IMPL;
   end
endmodule

// File: rtl/sdirq_mask.sv
module sdirq_mask
   import sdirq_pkg::*;
#(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] mask_q
);
   logic [DW-1:0] nxt;

   always_comb begin
      nxt = mask_q;
      if (we) begin
         case (reg_addr_e'(addr))
            A_MASK:   nxt = wdata;
            A_UNMASK: nxt = mask_q & ~wdata;
            A_DOMASK: nxt = mask_q | wdata;
            default:  nxt = mask_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= '1;
      else        mask_q <= nxt;
   end
endmodule

// File: rtl/sdirq_prio.sv
module sdirq_prio
   import sdirq_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] pend,
   output logic          irq,
   output logic [2:0]    cause
);
   localparam logic [DW-1:0] G_CARD = (DW'(1) << B_CIN)   | (DW'(1) << B_COUT);
   localparam logic [DW-1:0] G_CMD  = (DW'(1) << B_CDONE) | (DW'(1) << B_CTMO);
   localparam logic [DW-1:0] G_XFER = (DW'(1) << B_RXR)   | (DW'(1) << B_TXQ);
   localparam logic [DW-1:0] G_DEND = (DW'(1) << B_DEND);

   cause_e enc;
   logic   any;

   always_comb begin
      any = |pend;
      if      (|(pend & G_CARD)) enc = CZ_CARD;
      else if (|(pend & G_CMD))  enc = CZ_CMD;
      else if (|(pend & G_XFER)) enc = CZ_XFER;
      else if (|(pend & G_DEND)) enc = CZ_DEND;
      else                       enc = CZ_NONE;
   end

   generate
      if (REG_OUT) begin : g_reg
         logic       irq_q;
         logic [2:0] cause_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               irq_q   <= 1'b0;
               cause_q <= 3'd0;
            end else begin
               irq_q   <= any;
               cause_q <= enc;
            end
         end
         assign irq   = irq_q;
         assign cause = cause_q;
      end else begin : g_comb
         assign irq   = any;
         assign cause = enc;
      end
   endgenerate
endmodule

// File: rtl/sdirq_collector.sv
module sdirq_collector
   import sdirq_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [DW-1:0] evt_i,
   input  logic [1:0]    lvl_i,
   input  logic          wr_en,
   input  logic [1:0]    addr,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] rdata,
   output logic          irq_o,
   output logic [2:0]    cause_o
);
   localparam logic [DW-1:0] IMPL =
      (DW'(1) << B_CIN)   | (DW'(1) << B_COUT) |
      (DW'(1) << B_CDONE) | (DW'(1) << B_CTMO) |
      (DW'(1) << B_RXR)   | (DW'(1) << B_TXQ)  |
      (DW'(1) << B_DEND);

   generate
      if (DW < N_USED) begin : g_bad_width
         $error("sdirq_collector: DW too small for the status layout");
      end
   endgenerate

   logic [DW-1:0] stat_q;
   logic [DW-1:0] mask_q;
   logic [DW-1:0] pend;
   logic [DW-1:0] live;

   sdirq_status #(.DW(DW), .IMPL(IMPL)) u_stat (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i),
      .ack_we   (wr_en && (addr == A_STAT)),
      .ack_data (wdata),
      .stat_q   (stat_q)
   );

   sdirq_mask #(.DW(DW)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (wr_en),
      .addr   (addr),
      .wdata  (wdata),
      .mask_q (mask_q)
   );

   always_comb pend = stat_q & IMPL & ~mask_q;

   sdirq_prio #(.DW(DW), .REG_OUT(REG_OUT)) u_prio (
      .clk   (clk),
      .rst_n (rst_n),
      .pend  (pend),
      .irq   (irq_o),
      .cause (cause_o)
   );

   always_comb begin
      live  = (DW'(lvl_i[0]) << B_WP) | (DW'(lvl_i[1]) << B_SIG);
      rdata = (addr == A_STAT) ? (stat_q | live) : mask_q;
   end
endmodule

// File: rtl/sdirq_collector_chk.sv
module sdirq_collector_chk
   import sdirq_pkg::*;
#(
   parameter int unsigned DW      = 32,
   parameter bit          REG_OUT = 1'b1
) (
   input logic          clk,
   input logic          rst_n,
   input logic [DW-1:0] evt_i,
   input logic          wr_en,
   input logic [1:0]    addr,
   input logic [DW-1:0] wdata,
   input logic [DW-1:0] stat_q,
   input logic [DW-1:0] mask_q,
   input logic [DW-1:0] pend,
   input logic          irq_o,
   input logic [2:0]    cause_o
);
   localparam logic [DW-1:0] IMPL =
      (DW'(1) << B_CIN)   | (DW'(1) << B_COUT) |
      (DW'(1) << B_CDONE) | (DW'(1) << B_CTMO) |
      (DW'(1) << B_RXR)   | (DW'(1) << B_TXQ)  |
      (DW'(1) << B_DEND);
   localparam logic [DW-1:0] CARD = (DW'(1) << B_CIN) | (DW'(1) << B_COUT);

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (stat_q == '0 && mask_q == '1 && !irq_o));

   p_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (|(evt_i & IMPL)) |=> ((stat_q & $past(evt_i & IMPL)) == $past(evt_i & IMPL)));

   p_ack_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd0 && evt_i == '0) |=> (stat_q == ($past(stat_q) & $past(wdata))));

   p_unmask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd2) |=> ((mask_q & $past(wdata)) == '0));

   p_domask_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == 2'd3) |=> ((mask_q & $past(wdata)) == $past(wdata)));

   p_unimpl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_q & ~IMPL) == '0);

   generate
      if (REG_OUT) begin : g_reg_props
         p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (|pend) |=> irq_o);
         p_irq_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !(|pend) |=> !irq_o);
         p_all_masked_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (mask_q == '1) |=> !irq_o);
         p_card_first_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (|(pend & CARD)) |=> (cause_o == 3'd1));
      end
   endgenerate
endmodule

bind sdirq_collector sdirq_collector_chk #(.DW(DW), .REG_OUT(REG_OUT)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .evt_i   (evt_i),
   .wr_en   (wr_en),
   .addr    (addr),
   .wdata   (wdata),
   .stat_q  (stat_q),
   .mask_q  (mask_q),
   .pend    (pend),
   .irq_o   (irq_o),
   .cause_o (cause_o)
);

// File: tb/sdirq_collector_test.sv
module sdirq_collector_test;
   localparam int CLK_P = 10;
   localparam int DW    = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] evt_i = '0;
   logic [1:0]    lvl_i = 2'b00;
   logic          wr_en = 1'b0;
   logic [1:0]    addr = 2'd0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;
   logic          irq_o;
   logic [2:0]    cause_o;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   typedef struct {
      string         req;
      logic [DW-1:0] rd;
      logic          irq;
      logic [2:0]    cause;
   } exp_t;

   exp_t sb[$];
   event mon_ev;

   always #(CLK_P/2) clk = ~clk;

   sdirq_collector #(.DW(DW)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .lvl_i(lvl_i),
      .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .irq_o(irq_o), .cause_o(cause_o)
   );

   // monitor: pops expectations and compares with the ports
   initial begin
      forever begin
         @(mon_ev);
         while (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            total++;
            if (rdata !== e.rd || irq_o !== e.irq || cause_o !== e.cause) begin
               bad++;
               $display("FAIL %s: rdata=%h irq=%0b cause=%0d, expected rdata=%h irq=%0b cause=%0d",
                        e.req, rdata, irq_o, cause_o, e.rd, e.irq, e.cause);
            end
         end
      end
   end

   task automatic step();
      @(negedge clk);
   endtask

   task automatic expect_at(string req, logic [1:0] a, logic [DW-1:0] rd,
                            logic irq, logic [2:0] cause);
      exp_t e;
      addr = a;
      #1;
      e.req = req; e.rd = rd; e.irq = irq; e.cause = cause;
      sb.push_back(e);
      ->mon_ev;
      wait (sb.size() == 0);
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      step();
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic pulse(logic [DW-1:0] e);
      evt_i = e;
      step();
      evt_i = '0;
   endtask

   task automatic pulse_and_ack(logic [DW-1:0] e, logic [DW-1:0] d);
      evt_i = e; wr_en = 1'b1; addr = 2'd0; wdata = d;
      step();
      evt_i = '0; wr_en = 1'b0; wdata = '0;
   endtask

   initial begin
      #(CLK_P * 100000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   localparam logic [DW-1:0] IMPL_M = 32'h0000_01F3;

   initial begin
      step(); step();
      rst_n = 1'b1;
      step();
      // R1 reset state
      expect_at("R1 status", 2'd0, '0, 1'b0, 3'd0);
      expect_at("R1 mask", 2'd1, '1, 1'b0, 3'd0);

      // R2 + R6: command-done event while everything is masked
      pulse(32'h10);
      expect_at("R2 sticky set", 2'd0, 32'h10, 1'b0, 3'd0);
      step();
      expect_at("R6 masked no irq", 2'd0, 32'h10, 1'b0, 3'd0);

      // R5 enable implemented sources
      wr(2'd2, IMPL_M);
      expect_at("R5 unmask", 2'd1, ~IMPL_M, 1'b0, 3'd0);
      expect_at("R7 lag before", 2'd0, 32'h10, 1'b0, 3'd0);
      step();
      expect_at("R7 irq after one clock", 2'd0, 32'h10, 1'b1, 3'd2);

      // R8 ordering with data groups pending too
      pulse(32'h140);
      step();
      expect_at("R8 cmd over data", 2'd0, 32'h150, 1'b1, 3'd2);
      wr(2'd0, ~32'h10);
      expect_at("R3 zero clears, ones keep", 2'd0, 32'h140, 1'b1, 3'd2);
      step();
      expect_at("R8 xfer group", 2'd0, 32'h140, 1'b1, 3'd3);
      wr(2'd0, ~32'h40);
      step();
      expect_at("R8 data end group", 2'd0, 32'h100, 1'b1, 3'd4);
      pulse(32'h2);
      step();
      expect_at("R8 card first", 2'd0, 32'h102, 1'b1, 3'd1);

      // R4 event wins over same-cycle clear
      pulse_and_ack(32'h10, '0);
      expect_at("R4 event wins", 2'd0, 32'h10, 1'b1, 3'd1);
      step();
      expect_at("R4 cause after", 2'd0, 32'h10, 1'b1, 3'd2);

      wr(2'd0, '0);
      step();
      expect_at("R7 cleared quiet", 2'd0, '0, 1'b0, 3'd0);

      // R9 live levels
      lvl_i = 2'b01;
      expect_at("R9 write protect live", 2'd0, 32'h4, 1'b0, 3'd0);
      lvl_i = 2'b10;
      wr(2'd0, '0);
      step();
      expect_at("R9 signal state live", 2'd0, 32'h8, 1'b0, 3'd0);
      lvl_i = 2'b00;
      expect_at("R9 not latched", 2'd0, '0, 1'b0, 3'd0);

      // R10 unimplemented bits
      pulse(32'hFFFF_FE0C);
      step();
      expect_at("R10 ignored", 2'd0, '0, 1'b0, 3'd0);

      // R5 disable then direct write
      wr(2'd3, 32'h10);
      expect_at("R5 domask", 2'd1, ~IMPL_M | 32'h10, 1'b0, 3'd0);
      pulse(32'h10);
      step();
      expect_at("R6 disabled source", 2'd0, 32'h10, 1'b0, 3'd0);
      wr(2'd1, '0);
      expect_at("R5 direct mask", 2'd1, '0, 1'b0, 3'd0);
      step();
      expect_at("R5 direct mask irq", 2'd0, 32'h10, 1'b1, 3'd2);

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule